// File: doc/BRIEF.md
# Delay Line Phase Search Controller

This block steers a 9-bit delay code for an external delay line until a phase detector reports a chosen target phase, with the phase moving in a configured direction as the code increases. After a start pulse it walks candidate codes outward from a programmed start point, either downward, upward, or in alternating steps on both sides. For each candidate it waits for a measurement strobe before it samples the phase. When the phase equals the target, it makes one extra measurement at a neighbouring code to find the sign of the slope. It accepts the candidate only when that sign matches the configured one.

Once a candidate is accepted, the controller raises its lock flag. It then follows slow drift by moving the code one step per measurement toward the target. A search that runs out of legal codes, an invalid direction or an out-of-range target sets the error flag. The error flag stays set until the next start pulse. In manual mode the search is bypassed and the delay code simply follows the configured start value. In tracking mode the delay code output always shows the code in use.

Top module: `dly_phase_search`

## Requirements
- R1: `dly_code` never exceeds 431. A configured start value above 431 is used as 431.
- R2: A start pulse in tracking mode with a valid configuration loads the clamped start value into `dly_code` at the next clock edge.
- R3: Direction field `cfg_dir`: 2'b00 tries start, start-1, start-2 and so on. 2'b01 tries start, start+1 and so on. 2'b10 tries start, start+1, start-1, start+2, start-2 and so on, skipping any code outside 0..431.
- R4: `cfg_dir` = 2'b11 at a start pulse sets `search_err` and leaves `locked` low.
- R5: A target phase above 16 at a start pulse sets `search_err`, and the controller never locks for that run.
- R6: While a search is in progress, the delay code does not change in any cycle where `meas_valid` is low.
- R7: A candidate is accepted only if the measured phase equals the target and the slope test agrees with `cfg_slope_pos`. The slope test measures at the next code up, or the next code down at 431. The slope counts as positive (`cfg_slope_pos`=1) when the phase moves in the same direction as the code, and equal phases fail. On acceptance `dly_code` returns to the candidate and `locked` rises.
- R8: When no legal candidate remains, `search_err` is set and stays set until the next start pulse.
- R9: With `cfg_track`=0, `dly_code` follows the clamped `cfg_start_dly`, start pulses are ignored, and `locked` and `search_err` are low.
- R10: While locked, each valid measurement that differs from the target moves the code by one toward the target. The code moves up when (phase < target) equals `cfg_slope_pos`, and otherwise down. It never goes below 0 or above 431.
- R11: After reset `dly_code` is 216, and `locked` and `search_err` are low.
- R12: A start pulse restarts the search from any state, including the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new search |
| cfg_track | input | 1 | 1 = tracking (search) mode, 0 = manual mode |
| cfg_start_dly | input | 9 | Start code for a search, or the direct code in manual mode |
| cfg_dir | input | 2 | Search direction field |
| cfg_target | input | 5 | Target phase |
| cfg_slope_pos | input | 1 | Required slope sign, 1 = positive |
| meas_valid | input | 1 | Phase measurement strobe |
| meas_phase | input | 5 | Measured phase |
| dly_code | output | 9 | Delay code driven to the delay line |
| locked | output | 1 | Lock flag |
| search_err | output | 1 | Error flag |

## Verification
The hardest situation to reach from the ports is a phase match whose slope has the wrong sign, followed by a correct resumption of the search. The bench models the detector as a triangle wave of the code, so every target value occurs once on a rising flank and once on a falling flank. An upward search then meets the falling match first, and the only way to lock at the expected rising code is to reject that match. Tracking at the bottom boundary is reached by shifting the model so the match sits at code 0 and then drifting the phase upward.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    DIR_DOWN = 2'b00,
    DIR_UP   = 2'b01,
    DIR_BOTH = 2'b10,
    DIR_BAD  = 2'b11
  } dps_dir_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_MAN   = 3'd1,
    S_MEAS  = 3'd2,
    S_PROBE = 3'd3,
    S_LOCK  = 3'd4,
    S_ERR   = 3'd5
  } dps_state_e;

endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/dps_cand_gen.sv
module dps_cand_gen
  import dps_pkg::*;
#(
  parameter int CODE_W   = 9,
  parameter int CODE_MAX = 431
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic [1:0]        load_dir,
  input  logic              step,
  output logic [CODE_W-1:0] cur_code,
  output logic [CODE_W-1:0] next_code,
  output logic              has_next
);

  localparam int DW = CODE_W + 1;
  localparam logic [DW-1:0] MAXD = DW'(CODE_MAX);

  logic [CODE_W-1:0] base_q, base_d;
  logic [DW-1:0]     dist_q, dist_d;
  logic              up_q, up_d;
  logic [1:0]        dir_q, dir_d;

  logic [DW-1:0] n1_dist, n2_dist, nx_dist;
  logic          n1_up, n2_up, nx_up, two_way, ok1, ok2;

  function automatic logic legal_f(logic [DW-1:0] d, logic up, logic [CODE_W-1:0] b);
    if (up) return (({1'b0, b} + d) <= MAXD);
    else    return (d <= {1'b0, b});
  endfunction

  function automatic logic [CODE_W-1:0] code_f(logic [DW-1:0] d, logic up, logic [CODE_W-1:0] b);
    logic [DW-1:0] wide;
    wide = up ? ({1'b0, b} + d) : ({1'b0, b} - d);
    return wide[CODE_W-1:0];
  endfunction

  // Two positions of lookahead cover the one skip a side out of range can cause
  always_comb begin
    two_way = 1'b0;
    n1_dist = dist_q + DW'(1);
    n1_up   = 1'b0;
    case (dir_q)
      DIR_UP: n1_up = 1'b1;
      DIR_BOTH: begin
        two_way = 1'b1;
        if (up_q) begin
          n1_dist = dist_q;
          n1_up   = 1'b0;
        end else begin
          n1_up   = 1'b1;
        end
      end
      default: n1_up = 1'b0;
    endcase
    n2_dist = dist_q + DW'(1);
    n2_up   = two_way ? up_q : n1_up;
    ok1     = legal_f(n1_dist, n1_up, base_q);
    ok2     = two_way & legal_f(n2_dist, n2_up, base_q);
    nx_dist = ok1 ? n1_dist : n2_dist;
    nx_up   = ok1 ? n1_up : n2_up;
  end

  assign has_next  = ok1 | ok2;
  assign next_code = code_f(nx_dist, nx_up, base_q);
  assign cur_code  = code_f(dist_q, up_q, base_q);

  always_comb begin
    base_d = base_q;
    dist_d = dist_q;
    up_d   = up_q;
    dir_d  = dir_q;
    if (load) begin
      base_d = load_code;
      dist_d = '0;
      up_d   = (load_dir == DIR_UP);
      dir_d  = load_dir;
    end else if (step) begin
      dist_d = nx_dist;
      up_d   = nx_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dist_q <= '0;
      up_q   <= 1'b0;
      dir_q  <= DIR_DOWN;
    end else if (load || step) begin
      base_q <= base_d;
      dist_q <= dist_d;
      up_q   <= up_d;
      dir_q  <= dir_d;
    end
  end

  // R1: every candidate stays within the legal range
  a_r1_cand_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_code <= CODE_W'(CODE_MAX));

  // R8: the generator is only advanced when a further candidate exists
  a_r8_step_has_next: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |-> has_next);

endmodule

// File: rtl/dps_slope_eval.sv
module dps_slope_eval #(
  parameter int CODE_W = 9,
  parameter int PH_W   = 5
) (
  input  logic [CODE_W-1:0] base_code,
  input  logic [PH_W-1:0]   base_ph,
  input  logic [CODE_W-1:0] probe_code,
  input  logic [PH_W-1:0]   probe_ph,
  input  logic              want_pos,
  output logic              slope_ok
);

  logic code_rises, ph_rises, ph_flat;

  always_comb begin
    code_rises = (probe_code > base_code);
    ph_rises   = (probe_ph > base_ph);
    ph_flat    = (probe_ph == base_ph);
    slope_ok   = !ph_flat && ((code_rises == ph_rises) == want_pos);
  end

endmodule

// File: rtl/dps_track_step.sv
module dps_track_step #(
  parameter int CODE_W   = 9,
  parameter int CODE_MAX = 431,
  parameter int PH_W     = 5
) (
  input  logic [CODE_W-1:0] code,
  input  logic [PH_W-1:0]   phase,
  input  logic [PH_W-1:0]   target,
  input  logic              slope_pos,
  output logic [CODE_W-1:0] next_code
);

  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);

  logic go_up;

  always_comb begin
    go_up     = ((phase < target) == slope_pos);
    next_code = code;
    if (phase != target) begin
      if (go_up && (code < MAX_C))      next_code = code + CODE_W'(1);
      else if (!go_up && (code != '0))  next_code = code - CODE_W'(1);
    end
  end

endmodule

// File: rtl/dly_phase_search.sv
module dly_phase_search
  import dps_pkg::*;
#(
  parameter int CODE_W   = 9,
  parameter int CODE_MAX = 431,
  parameter int CODE_RST = 216,
  parameter int PH_W     = 5,
  parameter int PH_MAX   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_track,
  input  logic [CODE_W-1:0] cfg_start_dly,
  input  logic [1:0]        cfg_dir,
  input  logic [PH_W-1:0]   cfg_target,
  input  logic              cfg_slope_pos,
  input  logic              meas_valid,
  input  logic [PH_W-1:0]   meas_phase,
  output logic [CODE_W-1:0] dly_code,
  output logic              locked,
  output logic              search_err
);

  localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] RST_C   = CODE_W'(CODE_RST);
  localparam logic [PH_W-1:0]   PHMAX_C = PH_W'(PH_MAX);

  logic rst_s;

  dps_state_e        st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [PH_W-1:0]   tgt_q, bph_q;
  logic              pos_q;
  logic              locked_q, err_q;
  logic              cfg_en, bph_en;

  logic [CODE_W-1:0] start_clamped, probe_code, trk_code;
  logic [CODE_W-1:0] cg_code, cg_next;
  logic              cg_load, cg_step, cg_has_next, slope_ok;

  dps_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_s)
  );

  dps_cand_gen #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) i_cand_gen (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (cg_load),
    .load_code (start_clamped),
    .load_dir  (cfg_dir),
    .step      (cg_step),
    .cur_code  (cg_code),
    .next_code (cg_next),
    .has_next  (cg_has_next)
  );

  dps_slope_eval #(.CODE_W(CODE_W), .PH_W(PH_W)) i_slope_eval (
    .base_code  (cg_code),
    .base_ph    (bph_q),
    .probe_code (code_q),
    .probe_ph   (meas_phase),
    .want_pos   (pos_q),
    .slope_ok   (slope_ok)
  );

  dps_track_step #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX), .PH_W(PH_W)) i_track_step (
    .code      (code_q),
    .phase     (meas_phase),
    .target    (tgt_q),
    .slope_pos (pos_q),
    .next_code (trk_code)
  );

  assign start_clamped = (cfg_start_dly > MAX_C) ? MAX_C : cfg_start_dly;
  assign probe_code    = (cg_code < MAX_C) ? (cg_code + CODE_W'(1)) : (cg_code - CODE_W'(1));
  assign cfg_en        = cfg_track & start;

  always_comb begin
    st_d    = st_q;
    code_d  = code_q;
    cg_load = 1'b0;
    cg_step = 1'b0;
    bph_en  = 1'b0;
    if (!cfg_track) begin
      st_d   = S_MAN;
      code_d = start_clamped;
    end else if (start) begin
      if ((cfg_dir == DIR_BAD) || (cfg_target > PHMAX_C)) begin
        st_d = S_ERR;
      end else begin
        cg_load = 1'b1;
        code_d  = start_clamped;
        st_d    = S_MEAS;
      end
    end else begin
      case (st_q)
        S_MEAS: if (meas_valid) begin
          if (meas_phase == tgt_q) begin
            bph_en = 1'b1;
            code_d = probe_code;
            st_d   = S_PROBE;
          end else if (cg_has_next) begin
            cg_step = 1'b1;
            code_d  = cg_next;
          end else begin
            st_d = S_ERR;
          end
        end
        S_PROBE: if (meas_valid) begin
          if (slope_ok) begin
            code_d = cg_code;
            st_d   = S_LOCK;
          end else if (cg_has_next) begin
            cg_step = 1'b1;
            code_d  = cg_next;
            st_d    = S_MEAS;
          end else begin
            st_d = S_ERR;
          end
        end
        S_LOCK: if (meas_valid) code_d = trk_code;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q     <= S_IDLE;
      code_q   <= RST_C;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      code_q   <= code_d;
      locked_q <= (st_d == S_LOCK);
      err_q    <= (st_d == S_ERR);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tgt_q <= '0;
      pos_q <= 1'b1;
    end else if (cfg_en) begin
      tgt_q <= cfg_target;
      pos_q <= cfg_slope_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      bph_q <= '0;
    else if (bph_en) bph_q <= meas_phase;
  end

  assign dly_code   = code_q;
  assign locked     = locked_q;
  assign search_err = err_q;

  // R1: the delay line never sees an illegal code
  a_r1_code_legal: assert property (@(posedge clk) disable iff (!rst_s)
    dly_code <= MAX_C);

  // R6: no code change while a search waits for a measurement
  a_r6_wait_strobe: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_MEAS || st_q == S_PROBE) && !meas_valid && cfg_track && !start
    |=> $stable(dly_code));

  // R4: invalid direction reports an error
  a_r4_bad_dir: assert property (@(posedge clk) disable iff (!rst_s)
    start && cfg_track && (cfg_dir == 2'b11) |=> search_err && !locked);

  // R5: an out-of-range target reports an error
  a_r5_bad_target: assert property (@(posedge clk) disable iff (!rst_s)
    start && cfg_track && (cfg_target > PHMAX_C) |=> search_err && !locked);

  // R5: lock only ever holds for a legal target
  a_r5_lock_legal_target: assert property (@(posedge clk) disable iff (!rst_s)
    locked |-> tgt_q <= PHMAX_C);

  // R7: lock only follows a slope probe
  a_r7_lock_after_probe: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(locked) |-> $past(st_q) == S_PROBE);

  // R9: manual mode clears both flags
  a_r9_manual_flags: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg_track |=> !locked && !search_err);

  // R10: tracking moves the code by at most one per cycle
  a_r10_track_step: assert property (@(posedge clk) disable iff (!rst_s)
    locked && $past(locked) |->
      (dly_code == $past(dly_code)) ||
      (dly_code == $past(dly_code) + CODE_W'(1)) ||
      (dly_code + CODE_W'(1) == $past(dly_code)));

  // R8: the two flags never coexist
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    !(locked && search_err));

endmodule

// File: tb/test_dly_phase_search.sv
`timescale 1ns/1ps
module test_dly_phase_search;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       cfg_track;
  logic [8:0] cfg_start_dly;
  logic [1:0] cfg_dir;
  logic [4:0] cfg_target;
  logic       cfg_slope_pos;
  logic       meas_valid;
  logic [4:0] meas_phase;
  logic [8:0] dly_code;
  logic       locked;
  logic       search_err;

  int n_chk  = 0;
  int n_fail = 0;
  int off    = 0;
  bit inv    = 0;
  int vmode  = 0;
  int cyc    = 0;

  dly_phase_search i_dly_phase_search (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_track     (cfg_track),
    .cfg_start_dly (cfg_start_dly),
    .cfg_dir       (cfg_dir),
    .cfg_target    (cfg_target),
    .cfg_slope_pos (cfg_slope_pos),
    .meas_valid    (meas_valid),
    .meas_phase    (meas_phase),
    .dly_code      (dly_code),
    .locked        (locked),
    .search_err    (search_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Detector model: triangle of period 64 codes, optionally inverted
  function automatic int ph_of(int c, int o, bit iv);
    int v;
    int t;
    v = (c + o) % 64;
    if (v < 0) v += 64;
    t = (v < 32) ? v : 63 - v;
    return iv ? 31 - t : t;
  endfunction

  always_comb meas_phase = 5'(ph_of(int'(dly_code), off, inv));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    meas_valid <= (vmode == 0) ? 1'b1 : (vmode == 1) ? (cyc % 4 == 0) : 1'b0;

  function automatic bit good(int c, int tgt, bit pos);
    int n, pc, pn;
    bit rise;
    pc = ph_of(c, off, inv);
    if (pc != tgt) return 0;
    n  = (c < 431) ? c + 1 : c - 1;
    pn = ph_of(n, off, inv);
    if (pn == pc) return 0;
    rise = ((n > c) == (pn > pc));
    return rise == pos;
  endfunction

  function automatic int exp_lock(int s_in, int dir, int tgt, bit pos);
    int s;
    s = (s_in > 431) ? 431 : s_in;
    if (dir == 3 || tgt > 16) return -1;
    for (int d = 0; d <= 431; d++) begin
      if (dir == 0) begin
        if (s - d >= 0 && good(s - d, tgt, pos)) return s - d;
      end else if (dir == 1) begin
        if (s + d <= 431 && good(s + d, tgt, pos)) return s + d;
      end else if (d == 0) begin
        if (good(s, tgt, pos)) return s;
      end else begin
        if (s + d <= 431 && good(s + d, tgt, pos)) return s + d;
        if (s - d >= 0 && good(s - d, tgt, pos)) return s - d;
      end
    end
    return -1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic go(int s, int dir, int tgt, bit pos);
    @(negedge clk);
    cfg_track     = 1'b1;
    cfg_start_dly = 9'(s);
    cfg_dir       = 2'(dir);
    cfg_target    = 5'(tgt);
    cfg_slope_pos = pos;
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (locked || search_err) break;
      @(negedge clk);
    end
  endtask

  task automatic search_case(string req, int s, int dir, int tgt, bit pos);
    int e;
    go(s, dir, tgt, pos);
    wait_end();
    e = exp_lock(s, dir, tgt, pos);
    if (e >= 0) begin
      chk(locked && !search_err, req, "locked", int'(locked), 1);
      chk(int'(dly_code) == e, req, "lock code", int'(dly_code), e);
    end else begin
      chk(search_err && !locked, req, "error flag", int'(search_err), 1);
    end
  endtask

  task automatic t_reset();
    chk(dly_code == 9'd216, "R11", "reset code", int'(dly_code), 216);
    chk(!locked && !search_err, "R11", "reset flags", int'(locked) + int'(search_err), 0);
  endtask

  task automatic t_orders();
    off = 0; inv = 0; vmode = 0;
    search_case("R3 both", 216, 2, 14, 1'b1);
    search_case("R3 down", 216, 0, 14, 1'b1);
    search_case("R7 up rejects falling match", 216, 1, 14, 1'b1);
    search_case("R7 negative slope", 216, 1, 14, 1'b0);
    inv = 1;
    search_case("R7 inverted model", 216, 2, 14, 1'b1);
    inv = 0;
  endtask

  task automatic t_strobe();
    bit held;
    vmode = 2;
    go(100, 1, 14, 1'b1);
    held = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (dly_code != 9'd100 || locked) held = 1'b0;
      @(negedge clk);
    end
    chk(held, "R6", "code held without strobe", int'(dly_code), 100);
    vmode = 1;
    wait_end();
    chk(locked && dly_code == 9'(exp_lock(100, 1, 14, 1'b1)), "R6",
        "lock with sparse strobes", int'(dly_code), exp_lock(100, 1, 14, 1'b1));
    vmode = 0;
  endtask

  task automatic t_clamp();
    go(500, 1, 3, 1'b1);
    chk(dly_code == 9'd431, "R1 R2", "clamped start code", int'(dly_code), 431);
    wait_end();
    chk(search_err && !locked, "R1", "no match at top", int'(search_err), 1);
    search_case("R3 both skips above top", 500, 2, 14, 1'b1);
  endtask

  task automatic t_bad_cfg();
    bit never;
    go(216, 3, 14, 1'b1);
    repeat (3) @(negedge clk);
    chk(search_err && !locked, "R4", "invalid direction", int'(search_err), 1);
    go(216, 2, 17, 1'b1);
    never = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (locked) never = 1'b0;
      @(negedge clk);
    end
    chk(never && search_err, "R5", "target 17 never locks", int'(locked), 0);
  endtask

  task automatic t_exhaust();
    off = 20;
    go(3, 0, 5, 1'b1);
    wait_end();
    chk(search_err && !locked, "R8", "exhausted search", int'(search_err), 1);
    repeat (10) @(negedge clk);
    chk(search_err, "R8", "error sticky", int'(search_err), 1);
    off = 0;
    go(216, 2, 14, 1'b1);
    wait_end();
    chk(locked && dly_code == 9'd206, "R12", "restart after error", int'(dly_code), 206);
  endtask

  task automatic t_track();
    off = 0;
    search_case("R10 setup", 216, 1, 14, 1'b1);
    off = 1;
    repeat (4) @(negedge clk);
    chk(locked && dly_code == 9'd269, "R10", "step down on drift", int'(dly_code), 269);
    off = -1;
    repeat (6) @(negedge clk);
    chk(locked && dly_code == 9'd271, "R10", "step up on drift", int'(dly_code), 271);
  endtask

  task automatic t_track_edge();
    off = 14;
    search_case("R10 edge setup", 0, 1, 14, 1'b1);
    off = 15;
    repeat (5) @(negedge clk);
    chk(locked && dly_code == 9'd0, "R10", "clamp at zero", int'(dly_code), 0);
    off = 0;
  endtask

  task automatic t_manual();
    @(negedge clk);
    cfg_track     = 1'b0;
    cfg_start_dly = 9'd300;
    repeat (2) @(negedge clk);
    chk(dly_code == 9'd300, "R9", "manual code", int'(dly_code), 300);
    chk(!locked && !search_err, "R9", "manual flags", int'(locked) + int'(search_err), 0);
    cfg_start_dly = 9'd480;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(dly_code == 9'd431 && !locked, "R9 R1", "manual clamp, start ignored", int'(dly_code), 431);
    cfg_track = 1'b1;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n         = 1'b0;
    start         = 1'b0;
    cfg_track     = 1'b1;
    cfg_start_dly = 9'd216;
    cfg_dir       = 2'b10;
    cfg_target    = 5'd14;
    cfg_slope_pos = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_orders();
    t_strobe();
    t_clamp();
    t_bad_cfg();
    t_exhaust();
    t_track();
    t_track_edge();
    t_manual();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule